// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block is one performance-monitor counter. Every cycle it is handed an unsigned count of how often the monitored event happened in that cycle. A programmable test compares that count against a threshold, and the counter only advances on cycles that pass the test. On a passing cycle it adds either the full per-cycle count or exactly one, as a mode bit selects. The threshold, the comparison, the mode bit and an event number all sit in one 64-bit event-type register, which is written through a plain write strobe and can be read back.

The threshold hardware can be built at any width from 0 to 12 bits. A read-only capability word reports that width. When the width is zero, the threshold logic is absent and every cycle adds its raw count. A small two-state controller gates counting: `ST_IDLE` (counter frozen) moves to `ST_RUN` on the *start* transition (enable seen high), and `ST_RUN` returns to `ST_IDLE` on the *stop* transition (enable seen low). The counter value can be loaded directly. A wrap past the top of the counter sets a sticky overflow flag, which is cleared by a write-one-to-clear pulse.

Top module: `tqc_counter`

## Requirements
- R1: The event-type register `type_rdata` holds the event number in bits 15:0, the threshold in bits 43:32 and the threshold control in bits 63:61. All other bits read as zero. A write through `type_we` is visible on `type_rdata` and governs counting from the cycle after the write edge.
- R2: Threshold bits at or above the implemented width `TH_W` are dropped on write and read as zero. With `TH_W` = 0, the threshold and the control field both read as zero.
- R3: Control bits 63:62 select an unsigned comparison of the per-cycle count against the threshold: 0 = not equal, 1 = equal, 2 = greater than or equal, 3 = less than. A cycle that fails the comparison adds nothing.
- R4: When control bit 61 is 1, a passing cycle adds exactly 1. When it is 0, a passing cycle adds that cycle's full event count.
- R5: `cap_q` bits 23:20 report `TH_W`, and all other bits of `cap_q` are zero.
- R6: With `TH_W` = 0, every counting cycle adds the raw per-cycle count, whatever was written to the threshold and control fields.
- R7: The controller is in `ST_IDLE` after reset. It takes the start transition at the edge where `en` is 1, and the stop transition at the edge where `en` is 0. Counting happens only at edges where the state is already `ST_RUN`. At all other edges the counter holds its value.
- R8: `cnt_we` loads `cnt_wdata` into the counter at the edge. A load wins over any increment at that same edge. `cnt_q` shows the counter value.
- R9: An increment that carries out of the counter's top bit sets the sticky flag `ovf`. An `ovf_clr` pulse clears it. If a carry and a clear fall on the same edge, the flag is set.
- R10: After reset, the counter, the event-type register and `ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable, sampled by the run controller |
| evt_cnt | input | EVT_W | Number of events in this cycle |
| type_we | input | 1 | Event-type register write strobe |
| type_wdata | input | 64 | Event-type register write data |
| type_rdata | output | 64 | Event-type register contents |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| cnt_q | output | CNT_W | Counter value |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| ovf | output | 1 | Sticky overflow flag |
| cap_q | output | 32 | Capability word, threshold width in bits 23:20 |

## Verification
Two functions can collide on one edge. The first collision is an increment that carries out of the counter while `ovf_clr` is pulsed. The bench provokes it by loading all ones and then presenting one event with the clear held high. It judges the result by seeing `ovf` still set and the counter at zero. The second collision is a counter load together with a qualifying event. There, the loaded value must appear unchanged. A second instance built with no threshold hardware is driven in parallel, and each of its sums is compared with the raw counts.

// File: rtl/tqc_pkg.sv
package tqc_pkg;

    localparam int EVNUM_W   = 16;
    localparam int TH_LSB    = 32;
    localparam int TH_FLD_W  = 12;
    localparam int TC_LSB    = 61;

    typedef enum logic [1:0] {
        CMP_NE = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GE = 2'd2,
        CMP_LT = 2'd3
    } cmp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    typedef struct packed {
        logic [EVNUM_W-1:0]  evnum;
        logic [TH_FLD_W-1:0] th;
        cmp_e                cmp;
        logic                one_mode;
    } evtype_t;

    function automatic logic [63:0] keep_mask(input int th_w);
        logic [63:0] m;
        m = 64'h0;
        for (int i = 0; i < EVNUM_W; i++) m[i] = 1'b1;
        for (int i = 0; i < th_w; i++) m[TH_LSB+i] = 1'b1;
        if (th_w > 0) m[63:TC_LSB] = 3'b111;
        return m;
    endfunction

endpackage

// File: rtl/tqc_evtype_reg.sv
module tqc_evtype_reg
    import tqc_pkg::*;
#(
    parameter int TH_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [63:0]   wdata,
    output logic [63:0]   q,
    output evtype_t       fields
);
    localparam logic [63:0] KEEP = keep_mask(TH_W);
    localparam logic [TH_FLD_W-1:0] TH_KEEP = KEEP[TH_LSB +: TH_FLD_W];

    logic [63:0] q_r;

    always_ff @(posedge clk) begin
        if (!rst_n)  q_r <= '0;
        else if (we) q_r <= wdata & KEEP;
    end

    assign q               = q_r;
    assign fields.evnum    = q_r[EVNUM_W-1:0];
    assign fields.th       = q_r[TH_LSB +: TH_FLD_W];
    assign fields.cmp      = cmp_e'(q_r[63:62]);
    assign fields.one_mode = q_r[TC_LSB];

    AST_TH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q[TH_LSB +: TH_FLD_W] & ~TH_KEEP) == '0)); // R2

    generate
        if (TH_W == 0) begin : g_no_th
            AST_TC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> (q[63:TC_LSB] == 3'b000)); // R2
        end
    endgenerate
endmodule

// File: rtl/tqc_qualify.sv
module tqc_qualify
    import tqc_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int TH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt,
    input  evtype_t          f,
    output logic [EVT_W-1:0] inc
);
    localparam int CW = (EVT_W > TH_FLD_W) ? EVT_W : TH_FLD_W;

    generate
        if (TH_W == 0) begin : g_raw
            logic unused_raw;
            assign unused_raw = ^{f, clk, rst_n};
            assign inc = evt;
        end else begin : g_thr
            logic          hit;
            logic [CW-1:0] ev_x;
            logic [CW-1:0] th_x;
            logic          unused_evnum;

            assign unused_evnum = ^f.evnum;
            assign ev_x = CW'(evt);
            assign th_x = CW'(f.th);

            always_comb begin
                unique case (f.cmp)
                    CMP_NE: hit = (ev_x != th_x);
                    CMP_EQ: hit = (ev_x == th_x);
                    CMP_GE: hit = (ev_x >= th_x);
                    CMP_LT: hit = (ev_x <  th_x);
                    default: hit = 1'b0;
                endcase
                if (!hit)            inc = '0;
                else if (f.one_mode) inc = EVT_W'(1);
                else                 inc = evt;
            end

            AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                f.one_mode |-> (inc <= EVT_W'(1))); // R4
            AST_INC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                !f.one_mode |-> (inc == '0 || inc == evt)); // R3
        end
    endgenerate
endmodule

// File: rtl/tqc_run_ctrl.sv
module tqc_run_ctrl
    import tqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic active
);
    run_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (en)  state_nx = ST_RUN;
            ST_RUN:  if (!en) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RUN:  active = 1'b1;
            default: active = 1'b0;
        endcase
    end

    AST_START_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> active); // R7
    AST_STOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active); // R7
endmodule

// File: rtl/tqc_counter.sv
module tqc_counter
    import tqc_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int TH_W  = 8,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [EVT_W-1:0] evt_cnt,
    input  logic             type_we,
    input  logic [63:0]      type_wdata,
    output logic [63:0]      type_rdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    input  logic             ovf_clr,
    output logic             ovf,
    output logic [31:0]      cap_q
);
    localparam int CAP_LSB = 20;

    evtype_t          fields;
    logic [EVT_W-1:0] inc;
    logic             active;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_r;
    logic             ovf_r;
    logic             wrap;

    tqc_evtype_reg #(.TH_W(TH_W)) u_type (
        .clk(clk), .rst_n(rst_n), .we(type_we), .wdata(type_wdata),
        .q(type_rdata), .fields(fields)
    );

    tqc_qualify #(.EVT_W(EVT_W), .TH_W(TH_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .evt(evt_cnt), .f(fields), .inc(inc)
    );

    tqc_run_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .active(active)
    );

    assign sum  = {1'b0, cnt_r} + (CNT_W+1)'(inc);
    assign wrap = active && !cnt_we && sum[CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_r <= '0;
        else if (cnt_we) cnt_r <= cnt_wdata;
        else if (active) cnt_r <= sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_r <= 1'b0;
        else if (wrap)    ovf_r <= 1'b1;
        else if (ovf_clr) ovf_r <= 1'b0;
    end

    assign cnt_q = cnt_r;
    assign ovf   = ovf_r;
    assign cap_q = 32'(TH_W) << CAP_LSB;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(cnt_wdata))); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cnt_we) |=> $stable(cnt_q)); // R7
endmodule

// File: tb/tb_tqc_counter.sv
module tb_tqc_counter;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [7:0]  evt_cnt = '0;
    logic        type_we = 1'b0;
    logic [63:0] type_wdata = '0;
    logic        cnt_we = 1'b0;
    logic [63:0] cnt_wdata = '0;
    logic        ovf_clr = 1'b0;
    logic [63:0] type_rdata, cnt_q, r_type_rdata, r_cnt_q;
    logic        ovf, r_ovf;
    logic [31:0] cap_q, r_cap_q;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tqc_counter dut (
        .clk(clk), .rst_n(rst_n), .en(en), .evt_cnt(evt_cnt),
        .type_we(type_we), .type_wdata(type_wdata), .type_rdata(type_rdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
        .ovf_clr(ovf_clr), .ovf(ovf), .cap_q(cap_q)
    );

    tqc_counter #(.TH_W(0)) dut_raw (
        .clk(clk), .rst_n(rst_n), .en(en), .evt_cnt(evt_cnt),
        .type_we(type_we), .type_wdata(type_wdata), .type_rdata(r_type_rdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(r_cnt_q),
        .ovf_clr(ovf_clr), .ovf(r_ovf), .cap_q(r_cap_q)
    );

    // cmp[30:29] mode[28] threshold[27:16] events[15:8] expected add[7:0]
    localparam logic [30:0] VEC [NV] = '{
        {2'd2, 1'b1, 12'd2,     8'd1,   8'd0},
        {2'd2, 1'b1, 12'd2,     8'd2,   8'd1},
        {2'd2, 1'b1, 12'd2,     8'd5,   8'd1},
        {2'd2, 1'b0, 12'd2,     8'd5,   8'd5},
        {2'd1, 1'b0, 12'd7,     8'd7,   8'd7},
        {2'd1, 1'b0, 12'd7,     8'd6,   8'd0},
        {2'd0, 1'b0, 12'd4,     8'd4,   8'd0},
        {2'd0, 1'b0, 12'd4,     8'd9,   8'd9},
        {2'd3, 1'b0, 12'd4,     8'd3,   8'd3},
        {2'd3, 1'b0, 12'd4,     8'd4,   8'd0},
        {2'd3, 1'b1, 12'd4,     8'd0,   8'd1},
        {2'd2, 1'b0, 12'd255,   8'd255, 8'd255},
        {2'd2, 1'b0, 12'h1FF,   8'd255, 8'd255},
        {2'd2, 1'b0, 12'd0,     8'd0,   8'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [63:0] type_word(input logic [1:0] cmp, input logic mode,
                                              input logic [11:0] th);
        logic [63:0] w;
        w = 64'h0;
        w[63:62] = cmp;
        w[61]    = mode;
        w[43:32] = th;
        w[15:0]  = 16'h0023;
        return w;
    endfunction

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R5 capability
        chk("R10 cnt", cnt_q, 64'h0);
        chk("R10 ovf", {63'h0, ovf}, 64'h0);
        chk("R10 type", type_rdata, 64'h0);
        chk("R5 cap", {32'h0, cap_q}, 64'h0080_0000);
        chk("R5 cap raw", {32'h0, r_cap_q}, 64'h0);

        // R1 / R2 readback masks
        type_we = 1'b1; type_wdata = '1;
        @(negedge clk);
        type_we = 1'b0;
        chk("R1 type mask", type_rdata, 64'hE000_00FF_0000_FFFF);
        chk("R2 raw type mask", r_type_rdata, 64'h0000_0000_0000_FFFF);

        en = 1'b1;
        @(negedge clk);

        // vector table: R3 R4 R2 R6
        for (int i = 0; i < NV; i++) begin
            type_we = 1'b1;
            type_wdata = type_word(VEC[i][30:29], VEC[i][28], VEC[i][27:16]);
            cnt_we = 1'b1; cnt_wdata = 64'd100; evt_cnt = 8'd0;
            @(negedge clk);
            type_we = 1'b0; cnt_we = 1'b0; evt_cnt = VEC[i][15:8];
            @(negedge clk);
            evt_cnt = 8'd0;
            chk($sformatf("R3/R4 vec%0d", i), cnt_q, 64'd100 + 64'(VEC[i][7:0]));
            chk($sformatf("R6 raw vec%0d", i), r_cnt_q, 64'd100 + 64'(VEC[i][15:8]));
        end

        // R9 overflow with GE, threshold 0, full count
        type_we = 1'b1; type_wdata = type_word(2'd2, 1'b0, 12'd0);
        cnt_we = 1'b1; cnt_wdata = 64'hFFFF_FFFF_FFFF_FFFD;
        @(negedge clk);
        type_we = 1'b0; cnt_we = 1'b0; evt_cnt = 8'd5;
        @(negedge clk);
        evt_cnt = 8'd0;
        chk("R9 wrap cnt", cnt_q, 64'd2);
        chk("R9 wrap ovf", {63'h0, ovf}, 64'd1);
        @(negedge clk);
        chk("R9 sticky", {63'h0, ovf}, 64'd1);
        ovf_clr = 1'b1;
        @(negedge clk);
        chk("R9 clear", {63'h0, ovf}, 64'd0);
        ovf_clr = 1'b0; cnt_we = 1'b1; cnt_wdata = '1;
        @(negedge clk);
        cnt_we = 1'b0; evt_cnt = 8'd1; ovf_clr = 1'b1;
        @(negedge clk);
        chk("R9 set beats clear", {63'h0, ovf}, 64'd1);
        chk("R9 wrap to zero", cnt_q, 64'd0);

        // R8 load beats increment
        ovf_clr = 1'b0; evt_cnt = 8'd9; cnt_we = 1'b1; cnt_wdata = 64'h1234;
        @(negedge clk);
        cnt_we = 1'b0; evt_cnt = 8'd0;
        chk("R8 load wins", cnt_q, 64'h1234);

        // R7 enable latency
        en = 1'b0;
        @(negedge clk);
        evt_cnt = 8'd7;
        @(negedge clk);
        chk("R7 idle hold", cnt_q, 64'h1234);
        en = 1'b1;
        @(negedge clk);
        chk("R7 start edge no count", cnt_q, 64'h1234);
        @(negedge clk);
        evt_cnt = 8'd0;
        chk("R7 run counts", cnt_q, 64'h123B);

        finish_up();
    end
endmodule